// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit resolves the operand of a single load-style operation. The caller supplies a 4-bit mode code, a base register value, an index register value, a 13-bit signed constant, a scale factor and an access size. The unit then works out the operand address, runs one or two memory reads through a request/valid port, and returns the operand. Auto-increment and auto-decrement modes also return an updated base value for the register file to write back.

A small sequencer steps through an address phase, one or two memory phases and a one-cycle completion phase. Word accesses at an address that is not a multiple of four are refused with an alignment fault, and no memory request is made for them. Mode codes outside the defined set finish with an illegal-mode flag.

Top module: `ea_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `wb_en`, `align_fault` and `illegal_mode` are all low.
- R2: Mode 0 returns `base_val` and mode 1 returns the sign-extended 13-bit `disp`. Neither mode issues a memory request.
- R3: Four modes issue a single read at the address shown, and the operand is the returned data. Mode 2 reads at `base_val`. Mode 3 reads at `base_val` + sext(`disp`). Mode 4 reads at `base_val` + `idx_val`. Mode 5 reads at sext(`disp`).
- R4: Mode 6 first makes a word read at `base_val`. It then reads at the returned word, and that second read supplies the operand. The pointer read always uses word size.
- R5: Mode 7 reads at `base_val`. It completes with `wb_en` high and `wb_val` = `base_val` + step, where step is 1 for byte accesses and 4 for word accesses.
- R6: Mode 8 reads at `base_val` − step. It completes with `wb_en` high and `wb_val` = `base_val` − step.
- R7: Mode 9 reads at sext(`disp`) + `base_val` + `idx_val` × `scale`. The sum is taken modulo 2^32.
- R8: `is_word`=1 selects a 4-byte access. `is_word`=0 selects a 1-byte access, and its operand is `mem_rdata[7:0]` zero-extended. `mem_word` reports the size of each request.
- R9: A word access at an address with bits [1:0] ≠ 0 issues no request at that address. It completes with `align_fault` high, result 0 and `wb_en` low.
- R10: Mode codes 10 to 15 complete with `illegal_mode` high, result 0, `wb_en` low and no memory request.
- R11: `busy` is high from the cycle after `start` is accepted until completion. `done` is a one-cycle pulse. `start` is accepted only while the unit is idle and has no effect otherwise.
- R12: While `mem_req` is high and `mem_valid` is low, `mem_req`, `mem_addr` and `mem_word` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new operation while idle |
| mode | input | 4 | Addressing mode code |
| base_val | input | 32 | Base register value |
| idx_val | input | 32 | Index register value |
| disp | input | 13 | Signed displacement / immediate |
| scale | input | 4 | Unsigned index multiplier |
| is_word | input | 1 | 1 = word access, 0 = byte access |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Read address |
| mem_word | output | 1 | Request size, 1 = word |
| mem_valid | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Resolved operand |
| wb_en | output | 1 | Base write-back enable, valid with done |
| wb_val | output | 32 | Updated base value |
| align_fault | output | 1 | Misaligned word access, valid with done |
| illegal_mode | output | 1 | Undefined mode code, valid with done |

## Verification
Some properties hold on every cycle and are checked that way. These are the one-cycle `done` pulse, mutual exclusion of `busy` and `done`, the rule that no word request carries a misaligned address, the hold of the request while it waits, and the confinement of write-back to fault-free completions. Only the bench scenarios can show whether the address each mode computes is correct, how memory indirect chains its two reads, which byte a byte load selects, and what step auto-increment and auto-decrement apply. The bench checks these against a reference model under random memory latency.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_REG   = 4'd0,
    AM_IMM   = 4'd1,
    AM_IND   = 4'd2,
    AM_DISP  = 4'd3,
    AM_IDX   = 4'd4,
    AM_DIR   = 4'd5,
    AM_MIND  = 4'd6,
    AM_AINC  = 4'd7,
    AM_ADEC  = 4'd8,
    AM_SCL   = 4'd9
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_MEM1, ST_MEM2, ST_DONE
  } est_e;

  typedef struct packed {
    logic legal;
    logic uses_mem;
    logic two_reads;
    logic writes_base;
  } minfo_t;

  function automatic minfo_t mode_info(input logic [3:0] code);
    minfo_t r;
    r = '0;
    case (code)
      AM_REG, AM_IMM: r.legal = 1'b1;
      AM_IND, AM_DISP, AM_IDX, AM_DIR, AM_SCL: begin
        r.legal = 1'b1; r.uses_mem = 1'b1;
      end
      AM_MIND: begin
        r.legal = 1'b1; r.uses_mem = 1'b1; r.two_reads = 1'b1;
      end
      AM_AINC, AM_ADEC: begin
        r.legal = 1'b1; r.uses_mem = 1'b1; r.writes_base = 1'b1;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned DISP_W     = 13,
  parameter int unsigned SCALE_W    = 4,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [3:0]         mode,
  input  logic [XLEN-1:0]    base,
  input  logic [XLEN-1:0]    idx,
  input  logic [DISP_W-1:0]  disp,
  input  logic [SCALE_W-1:0] scale,
  input  logic               is_word,
  output logic [XLEN-1:0]    ea,
  output logic [XLEN-1:0]    next_base,
  output logic [XLEN-1:0]    imm_val
);

  function automatic logic [XLEN-1:0] sext(input logic [DISP_W-1:0] v);
    return {{(XLEN-DISP_W){v[DISP_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] step_of(input logic w);
    return w ? XLEN'(WORD_BYTES) : XLEN'(1);
  endfunction

  function automatic logic [XLEN-1:0] scaled(input logic [XLEN-1:0] i,
                                             input logic [SCALE_W-1:0] s);
    logic [XLEN-1:0] sw;
    sw = XLEN'(s);
    return i * sw;
  endfunction

  logic [XLEN-1:0] sx, step;
  assign sx      = sext(disp);
  assign step    = step_of(is_word);
  assign imm_val = sx;

  always_comb begin
    case (mode)
      AM_IND, AM_AINC, AM_MIND: ea = base;
      AM_DISP: ea = base + sx;
      AM_IDX:  ea = base + idx;
      AM_DIR:  ea = sx;
      AM_ADEC: ea = base - step;
      AM_SCL:  ea = sx + base + scaled(idx, scale);
      default: ea = '0;
    endcase
  end

  always_comb begin
    case (mode)
      AM_AINC: next_base = base + step;
      AM_ADEC: next_base = base - step;
      default: next_base = base;
    endcase
  end

endmodule

// File: rtl/ea_align_chk.sv
module ea_align_chk #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [XLEN-1:0] addr,
  input  logic            is_word,
  output logic            ok
);
  localparam int unsigned LSB = $clog2(WORD_BYTES);
  assign ok = !is_word || (addr[LSB-1:0] == '0);
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned DISP_W     = 13,
  parameter int unsigned SCALE_W    = 4,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [3:0]         mode_i,
  input  logic [XLEN-1:0]    base_i,
  input  logic [XLEN-1:0]    idx_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               word_i,
  output logic [3:0]         mode_q,
  output logic [XLEN-1:0]    base_q,
  output logic [XLEN-1:0]    idx_q,
  output logic [DISP_W-1:0]  disp_q,
  output logic [SCALE_W-1:0] scale_q,
  output logic               word_q,
  output logic               first_word,
  input  logic [XLEN-1:0]    ea,
  input  logic [XLEN-1:0]    next_base,
  input  logic [XLEN-1:0]    imm_val,
  input  logic               ea_ok,
  input  logic               ptr_ok,
  output logic               mem_req,
  output logic [XLEN-1:0]    mem_addr,
  output logic               mem_word,
  input  logic               mem_valid,
  input  logic [XLEN-1:0]    mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [XLEN-1:0]    result,
  output logic               wb_en,
  output logic [XLEN-1:0]    wb_val,
  output logic               align_fault,
  output logic               illegal_mode
);
  localparam int unsigned LSB = $clog2(WORD_BYTES);

  est_e            state;
  minfo_t          info;
  logic [XLEN-1:0] addr_q, res_q, wbv_q;
  logic            size_q, wb_q, flt_q, ill_q;
  logic            accept, last_beat;

  assign info       = mode_info(mode_q);
  assign first_word = word_q || (mode_q == AM_MIND);
  assign accept     = (state == ST_IDLE) && start;
  assign last_beat  = mem_valid && (state == ST_MEM2 ||
                      (state == ST_MEM1 && !info.two_reads));

  function automatic logic [XLEN-1:0] pick(input logic [XLEN-1:0] d,
                                           input logic w);
    return w ? d : {{(XLEN-8){1'b0}}, d[7:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      mode_q <= '0; base_q <= '0; idx_q <= '0; disp_q <= '0;
      scale_q <= '0; word_q <= 1'b0;
      addr_q <= '0; size_q <= 1'b0; res_q <= '0; wbv_q <= '0;
      wb_q <= 1'b0; flt_q <= 1'b0; ill_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          mode_q <= mode_i; base_q <= base_i; idx_q <= idx_i;
          disp_q <= disp_i; scale_q <= scale_i; word_q <= word_i;
          res_q <= '0; wb_q <= 1'b0; flt_q <= 1'b0; ill_q <= 1'b0;
          state <= ST_ADDR;
        end
        ST_ADDR: begin
          wbv_q <= next_base;
          if (!info.legal) begin
            ill_q <= 1'b1; state <= ST_DONE;
          end else if (!info.uses_mem) begin
            res_q <= (mode_q == AM_IMM) ? imm_val : base_q;
            state <= ST_DONE;
          end else if (!ea_ok) begin
            flt_q <= 1'b1; state <= ST_DONE;
          end else begin
            addr_q <= ea; size_q <= first_word; state <= ST_MEM1;
          end
        end
        ST_MEM1: if (mem_valid) begin
          if (info.two_reads) begin
            if (!ptr_ok) begin
              flt_q <= 1'b1; state <= ST_DONE;
            end else begin
              addr_q <= mem_rdata; size_q <= word_q; state <= ST_MEM2;
            end
          end else begin
            res_q <= pick(mem_rdata, size_q);
            wb_q  <= info.writes_base;
            state <= ST_DONE;
          end
        end
        ST_MEM2: if (mem_valid) begin
          res_q <= pick(mem_rdata, size_q);
          state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req      = (state == ST_MEM1) || (state == ST_MEM2);
  assign mem_addr     = addr_q;
  assign mem_word     = size_q;
  assign busy         = (state == ST_ADDR) || mem_req;
  assign done         = (state == ST_DONE);
  assign result       = res_q;
  assign wb_en        = done && wb_q;
  assign wb_val       = wbv_q;
  assign align_fault  = done && flt_q;
  assign illegal_mode = done && ill_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_word)));
  // R9
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_word) |-> (mem_addr[LSB-1:0] == '0));
  // R5
  wb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (!align_fault && !illegal_mode));
  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> (result == '0 && !wb_en && !align_fault));
  // R11
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!busy && !done && !mem_req));

  logic unused_last;
  assign unused_last = last_beat;

endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned DISP_W     = 13,
  parameter int unsigned SCALE_W    = 4,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [3:0]         mode,
  input  logic [XLEN-1:0]    base_val,
  input  logic [XLEN-1:0]    idx_val,
  input  logic [DISP_W-1:0]  disp,
  input  logic [SCALE_W-1:0] scale,
  input  logic               is_word,
  output logic               mem_req,
  output logic [XLEN-1:0]    mem_addr,
  output logic               mem_word,
  input  logic               mem_valid,
  input  logic [XLEN-1:0]    mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [XLEN-1:0]    result,
  output logic               wb_en,
  output logic [XLEN-1:0]    wb_val,
  output logic               align_fault,
  output logic               illegal_mode
);

  logic [3:0]         mode_q;
  logic [XLEN-1:0]    base_q, idx_q;
  logic [DISP_W-1:0]  disp_q;
  logic [SCALE_W-1:0] scale_q;
  logic               word_q, first_word;
  logic [XLEN-1:0]    ea, next_base, imm_val;
  logic               ea_ok, ptr_ok;

  ea_addr_gen #(.XLEN(XLEN), .DISP_W(DISP_W), .SCALE_W(SCALE_W),
                .WORD_BYTES(WORD_BYTES)) u_gen (
    .mode(mode_q), .base(base_q), .idx(idx_q), .disp(disp_q),
    .scale(scale_q), .is_word(word_q),
    .ea(ea), .next_base(next_base), .imm_val(imm_val)
  );

  ea_align_chk #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_al_ea (
    .addr(ea), .is_word(first_word), .ok(ea_ok)
  );

  ea_align_chk #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_al_ptr (
    .addr(mem_rdata), .is_word(word_q), .ok(ptr_ok)
  );

  ea_ctrl #(.XLEN(XLEN), .DISP_W(DISP_W), .SCALE_W(SCALE_W),
            .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mode_i(mode), .base_i(base_val), .idx_i(idx_val), .disp_i(disp),
    .scale_i(scale), .word_i(is_word),
    .mode_q(mode_q), .base_q(base_q), .idx_q(idx_q), .disp_q(disp_q),
    .scale_q(scale_q), .word_q(word_q), .first_word(first_word),
    .ea(ea), .next_base(next_base), .imm_val(imm_val),
    .ea_ok(ea_ok), .ptr_ok(ptr_ok),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_word(mem_word),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .result(result), .wb_en(wb_en),
    .wb_val(wb_val), .align_fault(align_fault), .illegal_mode(illegal_mode)
  );

endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [31:0] base_val = '0, idx_val = '0;
  logic [12:0] disp = '0;
  logic [3:0] scale = '0;
  logic is_word = 1'b0;
  logic mem_req, mem_word, busy, done, wb_en, align_fault, illegal_mode;
  logic [31:0] mem_addr, result, wb_val;
  logic mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0, nreq = 0;
  logic [31:0] last_addr = '0;

  always #2 clk = ~clk;

  ea_unit u0 (.*);

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F1E2D3C;
  endfunction

  always @(negedge clk) begin
    mem_valid = 1'b0;
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_valid = 1'b1;
        mem_rdata = memf(mem_addr);
        nreq++;
        last_addr = mem_addr;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] m, input logic [31:0] b, ix,
                       input logic [12:0] d, input logic [3:0] sc, input logic w,
                       output logic [31:0] res, output logic wbe,
                       output logic [31:0] wbv, output logic flt,
                       output logic ill, output int nr, output logic [31:0] la);
    logic [31:0] sx, st, a, p;
    sx = {{19{d[12]}}, d};
    st = w ? 32'd4 : 32'd1;
    res = 0; wbe = 0; wbv = 0; flt = 0; ill = 0; nr = 0; la = 0; a = 0;
    if (m == 0) res = b;
    else if (m == 1) res = sx;
    else if (m == 6) begin
      if (b[1:0] != 0) flt = 1;
      else begin
        p = memf(b);
        if (w && p[1:0] != 0) begin flt = 1; nr = 1; la = b; end
        else begin nr = 2; la = p; res = w ? memf(p) : {24'b0, memf(p)[7:0]}; end
      end
    end else if (m <= 9) begin
      case (m)
        2, 7: a = b;
        3: a = sx + b;
        4: a = ix + b;
        5: a = sx;
        8: a = b - st;
        default: a = b + sx + ix * {28'b0, sc};
      endcase
      if (w && a[1:0] != 0) flt = 1;
      else begin
        nr = 1; la = a;
        res = w ? memf(a) : {24'b0, memf(a)[7:0]};
        if (m == 7) begin wbe = 1; wbv = b + st; end
        if (m == 8) begin wbe = 1; wbv = a; end
      end
    end else ill = 1;
  endtask

  task automatic run_op(input logic [3:0] m, input logic [31:0] b, ix,
                        input logic [12:0] d, input logic [3:0] sc,
                        input logic w, input bit poke, input string tag);
    logic [31:0] er, ewv, ela; logic ewe, ef, ei; int enr; int n;
    model(m, b, ix, d, sc, w, er, ewe, ewv, ef, ei, enr, ela);
    @(negedge clk);
    nreq = 0; wcnt = 0;
    mode = m; base_val = b; idx_val = ix; disp = d; scale = sc; is_word = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {tag, " R11 busy after start"}, 32'(busy), 1);
    if (poke) begin
      mode = 4'd1; disp = 13'h0AA; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(done === 1'b1, {tag, " R11 completion"}, 32'(done), 1);
    chk(result === er, {tag, " R2 R3 R4 R7 R8 result"}, result, er);
    chk(nreq == enr, {tag, " R4 R9 R10 request count"}, 32'(nreq), 32'(enr));
    if (enr > 0) chk(last_addr === ela, {tag, " R3 R6 R7 address"}, last_addr, ela);
    chk(wb_en === ewe, {tag, " R5 R6 wb_en"}, 32'(wb_en), 32'(ewe));
    if (ewe) chk(wb_val === ewv, {tag, " R5 R6 wb_val"}, wb_val, ewv);
    chk(align_fault === ef, {tag, " R9 align_fault"}, 32'(align_fault), 32'(ef));
    chk(illegal_mode === ei, {tag, " R10 illegal_mode"}, 32'(illegal_mode), 32'(ei));
    @(negedge clk);
    chk(!done && !busy, {tag, " R11 single done, back to idle"}, 32'({done, busy}), 0);
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4720));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req && !wb_en && !align_fault && !illegal_mode,
        "R1 reset outputs", 32'({busy, done, mem_req, wb_en, align_fault, illegal_mode}), 0);
    rst_n = 1'b1;
    lat = 0;
    run_op(0, 32'h12345678, 0, 0, 0, 1, 0, "R2 reg");
    run_op(1, 0, 0, 13'h1FFF, 0, 1, 0, "R2 imm neg");
    run_op(2, 32'h100, 0, 0, 0, 1, 0, "R3 ind");
    run_op(3, 32'h1000, 0, 13'h1FFC, 0, 1, 0, "R3 disp neg");
    run_op(4, 32'h200, 32'h40, 0, 0, 0, 0, "R3 idx byte");
    run_op(5, 0, 0, 13'h0FFF, 0, 0, 0, "R3 dir byte");
    run_op(7, 32'h333, 0, 0, 0, 0, 0, "R5 ainc byte");
    run_op(7, 32'h400, 0, 0, 0, 1, 0, "R5 ainc word");
    run_op(8, 32'h0, 0, 0, 0, 1, 0, "R6 adec wrap");
    run_op(9, 32'h10, 32'h7, 13'h1FF0, 4'd4, 1, 0, "R7 scaled");
    run_op(9, 32'h10, 32'h7, 13'h3, 4'd15, 0, 0, "R7 scaled byte");
    run_op(2, 32'h102, 0, 0, 0, 1, 0, "R9 misaligned word");
    run_op(8, 32'h102, 0, 0, 0, 1, 0, "R9 adec misaligned");
    run_op(6, 32'h101, 0, 0, 0, 0, 0, "R4 R9 mind bad pointer addr");
    run_op(12, 32'h100, 0, 0, 0, 1, 0, "R10 illegal");
    lat = 3;
    run_op(6, 32'h0, 0, 0, 0, 0, 0, "R4 mind byte slow");
    run_op(3, 32'h800, 0, 13'h8, 0, 1, 1, "R11 start ignored while busy");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] b;
      b = $urandom;
      if ($urandom_range(0, 1) == 1) b[1:0] = 2'b00;
      lat = $urandom_range(0, 3);
      run_op(4'($urandom_range(0, 11)), b, $urandom, 13'($urandom), 4'($urandom),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0), "R12 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule